// File: doc/BRIEF.md
# Block-Transfer Bus Slave with Output FIFO

This block is the bus-facing slave of a data acquisition card on an asynchronous 32-bit-address backplane. The master drives the address, the address modifier (AM) and the strobes. The slave passes the strobes through synchronisers and decodes a two-register window. Register offset 0x0 is the control/status register (CSR). Register offset 0x8 is the data port. Acquisition logic pushes event words into an internal output FIFO. The master empties the FIFO through the data port, normally with 64-bit block transfers: the address strobe stays low and every data-strobe beat takes one word.

Writes to the CSR carry a command code in their low byte. The code arms the acquisition, fires a software trigger or clears the trigger processing units. Each code gives a one-cycle pulse on its own output. The acknowledge (DTACK) follows the strobes with fixed delays, so the acknowledge latency is the same for every beat.

The handshake machine has four states:
- IDLE: waits for the synchronised address strobe and both data strobes to be active. It then takes the IDLE→DECODE transition.
- DECODE: checks the address latched at the address-strobe edge. On a hit it takes DECODE→ACK, performs the pop or the command, and registers the read data. On a miss it takes DECODE→WAIT_REL.
- ACK: holds DTACK low until both strobes are inactive. It then takes ACK→IDLE.
- WAIT_REL: never drives DTACK. It waits for the strobes to go inactive and then takes WAIT_REL→IDLE.

Top module: `vme_mblt_slave`

## Requirements
- R1: After reset, DTACK (active low) is high, the data output enable is low, all three command pulses are low, and a CSR read returns 0.
- R2: The slave answers only when two conditions hold. First, address bits [31:16] equal BASE_ADDR[31:16] and address bits [15:0] are 0x0 or 0x8. Second, the AM code is 0x08, 0x09, 0x0C or 0x0D. For any other cycle DTACK is never asserted, no command fires and the FIFO is not popped.
- R3: Let the first rising clock edge that samples both data strobes low (with AS already synchronised) be edge 0. DTACK then goes low right after edge 3, which is 60 ns at 50 MHz.
- R4: Let the first rising edge that samples both data strobes high be edge 0. DTACK then returns high right after edge 2. It stays low for as long as a data strobe remains active.
- R5: A CSR read returns the following bits, and all other bits are 0:
  - bit 0: the armed flag.
  - bit 1: 1 when the output FIFO holds data.
  - bit 2: 1 when the FIFO is full.
- R6: A CSR write gives a one-cycle pulse on one output, selected by the low data byte:
  - 0x20 pulses cmd_arm and sets the armed flag.
  - 0x0A pulses cmd_trig.
  - 0x0C pulses cmd_clear.
  Any other byte gives no pulse.
- R7: The clear command also empties the output FIFO and clears the armed flag.
- R8: Each acknowledged data-port read beat pops one FIFO word, in push order. This includes consecutive beats under a single address strobe. During the beat the word is driven with the output enable high.
- R9: A data-port read from an empty FIFO returns 0xDEADBEEF_DEADBEEF and leaves the FIFO unchanged. A later push then reads back correctly.
- R10: A push while the FIFO is full is dropped, and push_full is high.
- R11: A data-port write is acknowledged with the normal timing and has no effect on the FIFO or the CSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vme_addr | input | 32 | Bus address |
| vme_am | input | 6 | Address modifier code |
| vme_as_n | input | 1 | Address strobe, active low, asynchronous |
| vme_ds0_n | input | 1 | Data strobe 0, active low, asynchronous |
| vme_ds1_n | input | 1 | Data strobe 1, active low, asynchronous |
| vme_write_n | input | 1 | Low for a write cycle |
| vme_data_in | input | 64 | Write data from the master |
| vme_data_out | output | 64 | Read data to the master |
| vme_data_oe | output | 1 | Read data driver enable |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| push_valid | input | 1 | Acquisition side pushes push_data |
| push_data | input | 64 | Word to store in the output FIFO |
| push_full | output | 1 | FIFO full; pushes are dropped |
| cmd_arm | output | 1 | One-cycle arm pulse |
| cmd_trig | output | 1 | One-cycle software trigger pulse |
| cmd_clear | output | 1 | One-cycle clear pulse |

## Verification
The bench builds the slave with FIFO_DEPTH set to 4, which brings the full flag and the dropped push within a few cycles. The other parameters keep their defaults: a two-stage synchroniser, a 16-bit decode boundary and a base of 0x0800_0000. With these defaults the measured strobe-to-acknowledge and release counts are the 3 and 2 edge values that the requirements state. Those values hold even though the bench runs at 125 MHz instead of 50 MHz, because they are counted in clock edges rather than nanoseconds. A scoreboard queue models the FIFO contents. Block reads that span an empty FIFO, a foreign AM code and a foreign base address show that an ignored cycle neither pops nor commands anything.

// File: rtl/vme_mblt_pkg.sv
package vme_mblt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACK,
        ST_WAIT_REL
    } hs_state_t;

    typedef enum logic {
        SEL_CSR,
        SEL_DATA
    } reg_sel_t;

    // command codes carried in the low byte of a CSR write
    localparam logic [7:0] CMD_CODE_ARM   = 8'h20;
    localparam logic [7:0] CMD_CODE_TRIG  = 8'h0A;
    localparam logic [7:0] CMD_CODE_CLEAR = 8'h0C;

    // accepted address modifiers: A32 data and A32 64-bit block, user/supervisor
    localparam logic [5:0] AM_A32_DATA_USR = 6'h09;
    localparam logic [5:0] AM_A32_DATA_SUP = 6'h0D;
    localparam logic [5:0] AM_A32_BLK_USR  = 6'h08;
    localparam logic [5:0] AM_A32_BLK_SUP  = 6'h0C;

    // CSR bit positions
    localparam int CSR_BIT_ARMED = 0;
    localparam int CSR_BIT_AVAIL = 1;
    localparam int CSR_BIT_FULL  = 2;

endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/vme_addr_decode.sv
module vme_addr_decode
    import vme_mblt_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                AM_W      = 6,
    parameter int                DEC_LSB   = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0800_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [AM_W-1:0]   am,
    output logic              hit,
    output reg_sel_t          sel
);

    localparam logic [DEC_LSB-1:0] OFF_CSR  = DEC_LSB'(0);
    localparam logic [DEC_LSB-1:0] OFF_DATA = DEC_LSB'(8);

    logic am_ok;
    logic base_ok;
    logic off_ok;
    logic [DEC_LSB-1:0] offset;

    assign offset  = addr[DEC_LSB-1:0];
    assign base_ok = (addr[ADDR_W-1:DEC_LSB] == BASE_ADDR[ADDR_W-1:DEC_LSB]);
    assign off_ok  = (offset == OFF_CSR) || (offset == OFF_DATA);

    always_comb begin
        unique case (am)
            AM_A32_DATA_USR,
            AM_A32_DATA_SUP,
            AM_A32_BLK_USR,
            AM_A32_BLK_SUP: am_ok = 1'b1;
            default:        am_ok = 1'b0;
        endcase
    end

    assign hit = am_ok && base_ok && off_ok;
    assign sel = (offset == OFF_DATA) ? SEL_DATA : SEL_CSR;

endmodule

// File: rtl/vme_out_fifo.sv
module vme_out_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CMAX);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/vme_mblt_slave.sv
module vme_mblt_slave
    import vme_mblt_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 64,
    parameter int                AM_W        = 6,
    parameter int                DEC_LSB     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h0800_0000,
    parameter int                FIFO_DEPTH  = 16,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vme_addr,
    input  logic [AM_W-1:0]   vme_am,
    input  logic              vme_as_n,
    input  logic              vme_ds0_n,
    input  logic              vme_ds1_n,
    input  logic              vme_write_n,
    input  logic [DATA_W-1:0] vme_data_in,
    output logic [DATA_W-1:0] vme_data_out,
    output logic              vme_data_oe,
    output logic              vme_dtack_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_full,
    output logic              cmd_arm,
    output logic              cmd_trig,
    output logic              cmd_clear
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [DATA_W-1:0] EMPTY_WORD = {(DATA_W/32){32'hDEAD_BEEF}};

    // strobe synchronisers
    logic [3:0] strobe_raw;
    logic [3:0] strobe_s;
    logic as_s_n, ds0_s_n, ds1_s_n, wr_s_n;

    assign strobe_raw = {vme_as_n, vme_ds0_n, vme_ds1_n, vme_write_n};

    vme_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'hF)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe_raw),
        .q     (strobe_s)
    );

    assign {as_s_n, ds0_s_n, ds1_s_n, wr_s_n} = strobe_s;

    logic as_act;
    logic as_act_q;
    logic ds_both;
    logic ds_any;

    assign as_act  = !as_s_n;
    assign ds_both = !ds0_s_n && !ds1_s_n;
    assign ds_any  = !ds0_s_n || !ds1_s_n;

    // address phase capture at the synchronised AS edge
    logic [ADDR_W-1:0] addr_q;
    logic [AM_W-1:0]   am_q;
    logic              wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_act_q <= 1'b0;
            addr_q   <= '0;
            am_q     <= '0;
            wr_q     <= 1'b0;
        end else begin
            as_act_q <= as_act;
            if (as_act && !as_act_q) begin
                addr_q <= vme_addr;
                am_q   <= vme_am;
                wr_q   <= !wr_s_n;
            end
        end
    end

    // decode
    logic     dec_hit;
    reg_sel_t dec_sel;

    vme_addr_decode #(
        .ADDR_W    (ADDR_W),
        .AM_W      (AM_W),
        .DEC_LSB   (DEC_LSB),
        .BASE_ADDR (BASE_ADDR)
    ) i_decode (
        .addr (addr_q),
        .am   (am_q),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    // output FIFO
    logic              fifo_pop;
    logic              fifo_flush;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CW-1:0]     fifo_count;

    vme_out_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .count     (fifo_count)
    );

    assign push_full = fifo_full;

    // handshake state machine
    hs_state_t state_q;
    hs_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (as_act && ds_both) state_d = ST_DECODE;
            ST_DECODE:   state_d = dec_hit ? ST_ACK : ST_WAIT_REL;
            ST_ACK:      if (!ds_any) state_d = ST_IDLE;
            ST_WAIT_REL: if (!ds_any) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access qualifiers in DECODE
    logic go_access;
    logic go_rd_data;
    logic go_rd_csr;
    logic go_wr_csr;
    logic armed_q;
    logic arm_d, trig_d, clear_d;
    logic [DATA_W-1:0] csr_word;

    assign go_access  = (state_q == ST_DECODE) && dec_hit;
    assign go_rd_data = go_access && !wr_q && (dec_sel == SEL_DATA);
    assign go_rd_csr  = go_access && !wr_q && (dec_sel == SEL_CSR);
    assign go_wr_csr  = go_access &&  wr_q && (dec_sel == SEL_CSR);

    always_comb begin
        arm_d   = 1'b0;
        trig_d  = 1'b0;
        clear_d = 1'b0;
        if (go_wr_csr) begin
            case (vme_data_in[7:0])
                CMD_CODE_ARM:   arm_d   = 1'b1;
                CMD_CODE_TRIG:  trig_d  = 1'b1;
                CMD_CODE_CLEAR: clear_d = 1'b1;
                default:        ;
            endcase
        end
    end

    always_comb begin
        csr_word = '0;
        csr_word[CSR_BIT_ARMED] = armed_q;
        csr_word[CSR_BIT_AVAIL] = !fifo_empty;
        csr_word[CSR_BIT_FULL]  = fifo_full;
    end

    assign fifo_pop   = go_rd_data && !fifo_empty;
    assign fifo_flush = clear_d;

    // registered outputs
    logic [DATA_W-1:0] rd_data_q;
    logic              dtack_n_q;
    logic              oe_q;
    logic              arm_q, trig_q, clear_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dtack_n_q <= 1'b1;
            oe_q      <= 1'b0;
            rd_data_q <= '0;
            arm_q     <= 1'b0;
            trig_q    <= 1'b0;
            clear_q   <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            dtack_n_q <= (state_d != ST_ACK);
            oe_q      <= (state_d == ST_ACK) && !wr_q;
            arm_q     <= arm_d;
            trig_q    <= trig_d;
            clear_q   <= clear_d;
            if (clear_d) begin
                armed_q <= 1'b0;
            end else if (arm_d) begin
                armed_q <= 1'b1;
            end
            if (go_rd_csr) begin
                rd_data_q <= csr_word;
            end else if (go_rd_data) begin
                rd_data_q <= fifo_empty ? EMPTY_WORD : fifo_head;
            end
        end
    end

    assign vme_dtack_n  = dtack_n_q;
    assign vme_data_oe  = oe_q;
    assign vme_data_out = rd_data_q;
    assign cmd_arm      = arm_q;
    assign cmd_trig     = trig_q;
    assign cmd_clear    = clear_q;

endmodule

// File: rtl/vme_mblt_slave_chk.sv
module vme_mblt_slave_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_hit,
    input logic          ds_any,
    input logic          vme_dtack_n,
    input logic          vme_data_oe,
    input logic          cmd_arm,
    input logic          cmd_trig,
    input logic          cmd_clear,
    input logic [CW-1:0] fifo_count
);

    assert_ack_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vme_dtack_n) |-> $past(dec_hit));

    assert_dtack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!vme_dtack_n && ds_any) |=> !vme_dtack_n);

    assert_pulse_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_arm, cmd_trig, cmd_clear}));

    assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_arm || cmd_trig || cmd_clear) |=> !(cmd_arm || cmd_trig || cmd_clear));

    assert_clear_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |-> (fifo_count == '0));

    assert_oe_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vme_data_oe |-> !vme_dtack_n);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(FIFO_DEPTH));

endmodule

bind vme_mblt_slave vme_mblt_slave_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CW         (CW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_hit     (dec_hit),
    .ds_any      (ds_any),
    .vme_dtack_n (vme_dtack_n),
    .vme_data_oe (vme_data_oe),
    .cmd_arm     (cmd_arm),
    .cmd_trig    (cmd_trig),
    .cmd_clear   (cmd_clear),
    .fifo_count  (fifo_count)
);

// File: tb/test_vme_mblt_slave.sv
module test_vme_mblt_slave;

    localparam int          DEPTH = 4;
    localparam logic [31:0] BASE  = 32'h0800_0000;
    localparam logic [63:0] EMPTY = 64'hDEAD_BEEF_DEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vme_addr = '0;
    logic [5:0]  vme_am = '0;
    logic        vme_as_n = 1'b1;
    logic        vme_ds0_n = 1'b1;
    logic        vme_ds1_n = 1'b1;
    logic        vme_write_n = 1'b1;
    logic [63:0] vme_data_in = '0;
    logic [63:0] vme_data_out;
    logic        vme_data_oe;
    logic        vme_dtack_n;
    logic        push_valid = 1'b0;
    logic [63:0] push_data = '0;
    logic        push_full;
    logic        cmd_arm, cmd_trig, cmd_clear;

    always #4 clk = ~clk;

    vme_mblt_slave #(.FIFO_DEPTH(DEPTH), .BASE_ADDR(BASE)) i_vme_mblt_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .vme_addr     (vme_addr),
        .vme_am       (vme_am),
        .vme_as_n     (vme_as_n),
        .vme_ds0_n    (vme_ds0_n),
        .vme_ds1_n    (vme_ds1_n),
        .vme_write_n  (vme_write_n),
        .vme_data_in  (vme_data_in),
        .vme_data_out (vme_data_out),
        .vme_data_oe  (vme_data_oe),
        .vme_dtack_n  (vme_dtack_n),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .push_full    (push_full),
        .cmd_arm      (cmd_arm),
        .cmd_trig     (cmd_trig),
        .cmd_clear    (cmd_clear)
    );

    int n_checks = 0;
    int n_errors = 0;
    int arm_cnt = 0, trig_cnt = 0, clr_cnt = 0, wide_cnt = 0;
    bit mon_data = 1'b0;
    bit done = 1'b0;
    logic [63:0] model_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // pulse monitor
    logic prev_any = 1'b0;
    always @(negedge clk) begin
        if (cmd_arm)   arm_cnt++;
        if (cmd_trig)  trig_cnt++;
        if (cmd_clear) clr_cnt++;
        if (prev_any && (cmd_arm || cmd_trig || cmd_clear)) wide_cnt++;
        prev_any = cmd_arm || cmd_trig || cmd_clear;
    end

    // scoreboard monitor: compares each acknowledged data-port read beat
    logic prev_dtack_n = 1'b1;
    always @(negedge clk) begin
        if (mon_data && prev_dtack_n && !vme_dtack_n) begin
            logic [63:0] exp;
            if (model_q.size() == 0) begin
                exp = EMPTY;
                check(vme_data_out == exp, "R9", "empty read word", vme_data_out, exp);
            end else begin
                exp = model_q.pop_front();
                check(vme_data_out == exp, "R8", "popped word", vme_data_out, exp);
            end
            check(vme_data_oe == 1'b1, "R8", "output enable in beat", 64'(vme_data_oe), 64'd1);
        end
        prev_dtack_n = vme_dtack_n;
    end

    // driver: push into design and into expected queue
    task automatic push_word(input logic [63:0] w);
        @(negedge clk);
        push_valid = 1'b1;
        push_data  = w;
        if (model_q.size() < DEPTH) model_q.push_back(w);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic bus_start(input logic [31:0] a, input logic [5:0] am,
                             input bit wr, input logic [63:0] wd);
        @(negedge clk);
        vme_addr    = a;
        vme_am      = am;
        vme_write_n = !wr;
        vme_data_in = wd;
        vme_as_n    = 1'b0;
        @(negedge clk);
    endtask

    task automatic beat(output bit acked, output int lat, output int rel,
                        output logic [63:0] rd);
        acked = 1'b0; lat = 0; rel = 0; rd = '0;
        vme_ds0_n = 1'b0;
        vme_ds1_n = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (!vme_dtack_n) begin
                acked = 1'b1; lat = i; rd = vme_data_out;
                break;
            end
        end
        vme_ds0_n = 1'b1;
        vme_ds1_n = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (vme_dtack_n) begin
                rel = i;
                break;
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_end();
        vme_as_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic csr_write(input logic [7:0] code, input logic [5:0] am,
                             input logic [31:0] a, output bit acked,
                             output int lat, output int rel);
        logic [63:0] rd;
        bus_start(a, am, 1'b1, {56'h0, code});
        beat(acked, lat, rel, rd);
        bus_end();
    endtask

    task automatic csr_read(output logic [63:0] rd);
        bit acked; int lat, rel;
        bus_start(BASE, 6'h09, 1'b0, '0);
        beat(acked, lat, rel, rd);
        bus_end();
    endtask

    task automatic block_read(input int n, input logic [31:0] a, input logic [5:0] am,
                              output bit all_acked);
        bit acked; int lat, rel; logic [63:0] rd;
        all_acked = 1'b1;
        bus_start(a, am, 1'b0, '0);
        mon_data = 1'b1;
        for (int k = 0; k < n; k++) begin
            beat(acked, lat, rel, rd);
            if (!acked) all_acked = 1'b0;
        end
        mon_data = 1'b0;
        bus_end();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            check(1'b0, "WATCHDOG", "run did not complete", 64'd0, 64'd1);
            finish_sim();
        end
    end

    initial begin
        bit acked; int lat, rel; logic [63:0] rd; bit ok;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(vme_dtack_n == 1'b1, "R1", "dtack_n in reset", 64'(vme_dtack_n), 64'd1);
        check(vme_data_oe == 1'b0, "R1", "oe in reset", 64'(vme_data_oe), 64'd0);
        check({cmd_arm, cmd_trig, cmd_clear} == 3'b0, "R1", "pulses in reset",
              64'({cmd_arm, cmd_trig, cmd_clear}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        csr_read(rd);
        check(rd == 64'd0, "R1", "CSR after reset", rd, 64'd0);

        // R6 arm, with R3/R4 timing
        csr_write(8'h20, 6'h09, BASE, acked, lat, rel);
        check(acked, "R3", "CSR write acked", 64'(acked), 64'd1);
        check(lat == 4, "R3", "DS to DTACK edges", 64'(lat), 64'd4);
        check(rel == 3, "R4", "DS release to DTACK release", 64'(rel), 64'd3);
        check(arm_cnt == 1, "R6", "arm pulse count", 64'(arm_cnt), 64'd1);
        csr_read(rd);
        check(rd == 64'h1, "R5", "CSR armed only", rd, 64'h1);

        // R6 trigger and unknown code
        csr_write(8'h0A, 6'h0D, BASE, acked, lat, rel);
        check(trig_cnt == 1 && arm_cnt == 1 && clr_cnt == 0, "R6", "trig pulse",
              64'(trig_cnt), 64'd1);
        csr_write(8'h55, 6'h09, BASE, acked, lat, rel);
        check(acked && arm_cnt == 1 && trig_cnt == 1 && clr_cnt == 0, "R6",
              "unknown code no pulse", 64'(arm_cnt + trig_cnt + clr_cnt), 64'd2);

        // R8 block read past empty into R9
        push_word(64'h1111_0000_0000_0001);
        push_word(64'h2222_0000_0000_0002);
        push_word(64'h3333_0000_0000_0003);
        csr_read(rd);
        check(rd == 64'h3, "R5", "CSR armed and data present", rd, 64'h3);
        block_read(4, BASE | 32'h8, 6'h08, ok);
        check(ok, "R8", "all block beats acked", 64'(ok), 64'd1);
        csr_read(rd);
        check(rd == 64'h1, "R9", "CSR after drain", rd, 64'h1);

        // R9 no underflow: push then read returns that word
        push_word(64'hCAFE_F00D_0000_0009);
        block_read(1, BASE | 32'h8, 6'h0C, ok);
        check(ok, "R9", "read after empty acked", 64'(ok), 64'd1);

        // R10 overflow drop
        for (int k = 0; k < DEPTH + 1; k++) push_word(64'hA000_0000_0000_0000 | 64'(k));
        check(push_full == 1'b1, "R10", "push_full", 64'(push_full), 64'd1);
        csr_read(rd);
        check(rd == 64'h7, "R10", "CSR full", rd, 64'h7);
        block_read(DEPTH + 1, BASE | 32'h8, 6'h08, ok);

        // R11 data port write ignored
        push_word(64'h5555_0000_0000_0001);
        push_word(64'h6666_0000_0000_0002);
        bus_start(BASE | 32'h8, 6'h09, 1'b1, 64'h0BAD_0BAD_0BAD_0BAD);
        beat(acked, lat, rel, rd);
        bus_end();
        check(acked && lat == 4, "R11", "data write acked", 64'(lat), 64'd4);
        csr_read(rd);
        check(rd == 64'h3, "R11", "CSR unchanged by data write", rd, 64'h3);

        // R2 foreign AM and foreign base
        csr_write(8'h0C, 6'h29, BASE, acked, lat, rel);
        check(!acked, "R2", "foreign AM acked", 64'(acked), 64'd0);
        check(clr_cnt == 0, "R2", "foreign AM clear pulse", 64'(clr_cnt), 64'd0);
        bus_start(BASE + 32'h0001_0008, 6'h09, 1'b0, '0);
        beat(acked, lat, rel, rd);
        bus_end();
        check(!acked, "R2", "foreign base acked", 64'(acked), 64'd0);
        block_read(1, BASE | 32'h8, 6'h09, ok);
        check(ok, "R2", "no pop by ignored cycle", 64'(ok), 64'd1);

        // R7 clear flushes and disarms
        csr_write(8'h0C, 6'h09, BASE, acked, lat, rel);
        model_q.delete();
        check(clr_cnt == 1, "R7", "clear pulse", 64'(clr_cnt), 64'd1);
        csr_read(rd);
        check(rd == 64'h0, "R7", "CSR after clear", rd, 64'h0);
        block_read(1, BASE | 32'h8, 6'h08, ok);

        check(wide_cnt == 0, "R6", "pulse wider than one cycle", 64'(wide_cnt), 64'd0);
        done = 1'b1;
        finish_sim();
    end

endmodule